// File: doc/BRIEF.md
# Configuration Word Checksum Checker

This block checks a block of 16-bit configuration words as they stream past. The words arrive one per qualified cycle. The block does not store them. Software or a loader pulses `start` and presents the block length on the same cycle. It then feeds the words in order, and idle cycles may fall between them.

Every word except the last is added into a 32-bit running sum. The last word carries the expected checksum. When that word arrives, the block raises `done` for one cycle. It also sets `pass` when both of these hold:
- the low 16 bits of the sum equal the checksum word;
- the full 32-bit sum is not zero.

The zero-sum rule rejects blank or erased contents. In that case the checksum of all-zero words would otherwise match.

Top module: `cfg_sum_check`

## Requirements
- R1: While `rst_n` is low, and after it is released, `done` and `pass` are 0 and the checker is idle until a `start` pulse.
- R2: A `start` pulse clears the running sum, the word index and `pass`, and arms the checker. A word presented in the same cycle as `start` is not counted.
- R3: Each accepted word with index 0 to L-2 (L = block length) is added, zero-extended, into a 32-bit sum. Cycles with `word_valid` low leave the sum and the index unchanged.
- R4: The accepted word with index L-1 is the checksum. `done` is 1 for exactly the one cycle after the clock edge that accepts it.
- R5: In the cycle `done` is high, `pass` is 1 when the sum is nonzero and its low 16 bits equal the checksum word, and 0 otherwise.
- R6: A block whose 32-bit sum is exactly zero fails, even when the checksum word is 0x0000.
- R7: `pass` keeps its value from `done` until the next `start`, which clears it to 0.
- R8: Words presented while the checker is not armed have no effect on `done`, `pass` or the sum. This covers words before any `start` and words after `done`.
- R9: The length is captured at `start`. A length of 0 or 1 means the first accepted word is the checksum over an empty sum, so the block fails.
- R10: Carries above bit 15 are kept in the sum and only the low 16 bits are compared. For example, 0xFFFF + 0x0002 with checksum 0x0001 passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a new block; clears sum, index and result |
| len | input | LEN_W (8) | Number of words in the block including the checksum, sampled at `start` |
| word_valid | input | 1 | `word_data` holds a word this cycle |
| word_data | input | WORD_W (16) | Configuration or checksum word |
| done | output | 1 | One-cycle strobe after the checksum word is accepted |
| pass | output | 1 | Result of the last completed block |

## Verification
The assertions assume that `start` is never raised for a block while its own words are arriving. They also assume that `len` is meaningful only at `start`, so a result always belongs to a single block. The stimulus honours both assumptions. Each block opens with one `start` pulse and then delivers exactly its declared number of words. The only departures are deliberate: a start that coincides with a word, and words sent while the checker is disarmed. The zero-extended sum stays well inside 32 bits for the lengths used, so the assertions never see the accumulator wrap.

// File: rtl/cfg_sum_check.sv
module cfg_sum_check #(
  parameter int WORD_W = 16,
  parameter int ACC_W  = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              done,
  output logic              pass
);
  localparam int PAD_W = ACC_W - WORD_W;

  logic              armed;
  logic [LEN_W-1:0]  cnt;
  logic [LEN_W-1:0]  last_idx;
  logic [ACC_W-1:0]  acc;
  logic              done_q;
  logic              pass_q;

  wire take    = armed && word_valid && !start;
  wire is_last = (cnt == last_idx);
  wire verdict = (acc != '0) && (acc[WORD_W-1:0] == word_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      cnt      <= '0;
      last_idx <= '0;
      acc      <= '0;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        armed    <= 1'b1;
        cnt      <= '0;
        acc      <= '0;
        pass_q   <= 1'b0;
        last_idx <= (len == '0) ? '0 : len - 1'b1;
      end else if (take) begin
        if (is_last) begin
          armed  <= 1'b0;
          done_q <= 1'b1;
          pass_q <= verdict;
        end else begin
          acc <= acc + {{PAD_W{1'b0}}, word_data};
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign pass = pass_q;
endmodule

module cfg_sum_check_sva #(
  parameter int WORD_W = 16,
  parameter int ACC_W  = 32,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              word_valid,
  input logic [WORD_W-1:0] word_data,
  input logic              done,
  input logic              pass,
  input logic              armed,
  input logic [LEN_W-1:0]  cnt,
  input logic [LEN_W-1:0]  last_idx,
  input logic [ACC_W-1:0]  acc
);
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(word_valid) && $past(armed) && !$past(start)));

  p_pass_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> (acc != '0));

  p_pass_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> (acc[WORD_W-1:0] == $past(word_data)));

  p_pass_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pass) |-> (done || $past(start)));

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cnt <= last_idx));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !start) |=> ($stable(acc) && !done));
endmodule

bind cfg_sum_check cfg_sum_check_sva #(
  .WORD_W(WORD_W), .ACC_W(ACC_W), .LEN_W(LEN_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .word_valid(word_valid),
  .word_data(word_data), .done(done), .pass(pass), .armed(armed),
  .cnt(cnt), .last_idx(last_idx), .acc(acc)
);

// File: tb/cfg_sum_check_tb.sv
module cfg_sum_check_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  len = '0;
  logic        word_valid = 1'b0;
  logic [15:0] word_data = '0;
  logic        done;
  logic        pass;

  int n_run = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cfg_sum_check u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len),
    .word_valid(word_valid), .word_data(word_data),
    .done(done), .pass(pass)
  );

  // {len[3:0], w0, w1, w2, w3, w4, expected pass}
  localparam int NV = 8;
  localparam logic [84:0] VEC [NV] = '{
    {4'd3, 16'h1234, 16'h0001, 16'h1235, 16'h0, 16'h0, 1'b1},
    {4'd3, 16'h1234, 16'h0001, 16'h1236, 16'h0, 16'h0, 1'b0},
    {4'd3, 16'h0000, 16'h0000, 16'h0000, 16'h0, 16'h0, 1'b0},
    {4'd3, 16'hFFFF, 16'h0002, 16'h0001, 16'h0, 16'h0, 1'b1},
    {4'd5, 16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h000A, 1'b1},
    {4'd2, 16'h8000, 16'h8000, 16'h0, 16'h0, 16'h0, 1'b1},
    {4'd1, 16'h0000, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0},
    {4'd5, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFC, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [7:0] l);
    @(negedge clk);
    start = 1'b1; len = l;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(input logic [15:0] w, input bit gap);
    if (gap) begin
      word_valid = 1'b0;
      @(negedge clk);
    end
    word_valid = 1'b1; word_data = w;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  bit fin = 1'b0;

  initial begin
    #1_000_000;
    if (!fin) begin
      n_bad++; n_run++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done in reset", 32'(done), 0);
    chk("R1 pass in reset", 32'(pass), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", 32'(done), 0);

    // R8: words before any start are ignored
    for (int i = 0; i < 4; i++) begin
      send(16'h0000, 1'b0);
      chk("R8 no done while idle", 32'(done), 0);
    end
    chk("R8 pass idle", 32'(pass), 0);

    // Table walk (R3 R4 R5 R6 R9 R10)
    for (int v = 0; v < NV; v++) begin
      logic [3:0] l;
      l = VEC[v][84:81];
      do_start({4'd0, l});
      for (int k = 0; k < int'(l); k++) begin
        send(VEC[v][80-16*k -: 16], (k % 2) == 1);
        if (k < int'(l) - 1) chk("R4 no early done", 32'(done), 0);
      end
      chk($sformatf("R4 done vec %0d", v), 32'(done), 1);
      chk($sformatf("R5 pass vec %0d", v), 32'(pass), 32'(VEC[v][0]));
      @(negedge clk);
      chk("R4 done one cycle", 32'(done), 0);
    end

    // R7: pass holds after done, R8: words after done ignored
    do_start(8'd2);
    send(16'h0042, 1'b0);
    send(16'h0042, 1'b0);
    chk("R5 pass set", 32'(pass), 1);
    for (int i = 0; i < 3; i++) begin
      send(16'h0000, 1'b0);
      chk("R8 no done after block", 32'(done), 0);
      chk("R7 pass holds", 32'(pass), 1);
    end
    do_start(8'd2);
    chk("R7 start clears pass", 32'(pass), 0);

    // R2: word coincident with start is not counted
    @(negedge clk);
    start = 1'b1; len = 8'd2; word_valid = 1'b1; word_data = 16'h0005;
    @(negedge clk);
    start = 1'b0; word_valid = 1'b0;
    chk("R2 no done at start", 32'(done), 0);
    send(16'h0007, 1'b0);
    chk("R2 block not complete yet", 32'(done), 0);
    send(16'h0007, 1'b0);
    chk("R2 done", 32'(done), 1);
    chk("R2 start word excluded", 32'(pass), 1);

    // R9: len 0 behaves as len 1 (checksum only, zero sum fails)
    do_start(8'd0);
    send(16'h0000, 1'b0);
    chk("R9 len0 done", 32'(done), 1);
    chk("R9 len0 fails", 32'(pass), 0);

    // R6: nonzero high bits but zero low bits passes only if sum nonzero
    do_start(8'd3);
    send(16'h8000, 1'b0);
    send(16'h8000, 1'b0);
    send(16'h0000, 1'b0);
    chk("R6 sum 0x10000 with ck 0 passes", 32'(pass), 1);

    // R1: reset mid-block clears state
    do_start(8'd3);
    send(16'h0001, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    send(16'h0001, 1'b0);
    send(16'h0002, 1'b0);
    chk("R1 reset disarms", 32'(done), 0);
    chk("R1 reset clears pass", 32'(pass), 0);

    fin = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule